// File: doc/BRIEF.md
# NOR Flash Command Decoder Model

This block is a synthesizable, device-side model of how a parallel NOR flash interprets bus write cycles. A host drives an active-low write strobe with an address and a data word. The model decodes keyed multi-cycle command sequences. These start word programming, sector erase, whole-array erase, and entry to or exit from identification mode. Storage is a small internal array of data words, and it comes out of reset in the erased state, with every bit set to 1.

After a program or erase command, the model enters a busy phase. Its length is a parameter counted in clock cycles. During that phase every read returns a status word instead of array data, and two status bits flip on each read. A host can therefore poll the model until two consecutive reads agree. In identification mode, two low addresses return the vendor and device codes. An active-low write-protect input blocks whole-array erase.

Top module: `nor_cmd_model`

## Requirements
- R1: After reset every array word reads 0xFFFF, identification mode is off, no busy phase is running, and rd_data_o is 0.
- R2: A sequence starts with low data byte 0xAA at address 0x5555, followed by 0x55 at 0x2AAA. Addresses are compared over the full address width. Any write that does not fit the expected step returns the decoder to idle, and that write has no effect.
- R3: After the two keys, 0xA0 at 0x5555 arms programming. The next write programs its word, and the stored value becomes the old value ANDed with the written data.
- R4: After the two keys, 0x80 at 0x5555 followed by the two keys again arms erase. A sixth write with low byte 0x30 or 0x50 at any address then sets every word of the sector selected by address bits [MEM_AW-1:SECT_AW] to 0xFFFF. Other sectors keep their contents.
- R5: A sixth write of 0x10 at 0x5555 in the armed-erase state sets every array word to 0xFFFF while wp_ni is high. While wp_ni is low, it does nothing and starts no busy phase.
- R6: A started program or erase holds the model busy for PROG_CYC, SECT_CYC or CHIP_CYC cycles. During that time a read returns a word in which only bits 6 and 2 may be set, and those two bits are equal. The first such read after the start returns 0x0000, and each later one inverts both bits.
- R7: Writes that complete while busy change neither the array nor the decoder state.
- R8: After the two keys, 0x90 at 0x5555 enters identification mode. In that mode address 0 reads MFR_ID, address 1 reads DEV_ID, and other addresses read the array. After the two keys, 0xF0 at 0x5555 leaves the mode.
- R9: The address of a write is taken in the clock cycle in which wr_n_i is first seen low. The data is taken in the cycle in which wr_n_i is first seen high again.
- R10: rd_data_o updates in the clock cycle after rd_i is high, and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_n_i | input | 1 | Write strobe, active low, synchronous to clk_i |
| rd_i | input | 1 | Read request for addr_i |
| addr_i | input | AW | Word address for reads and writes |
| data_i | input | DW | Write data |
| wp_ni | input | 1 | Write protect, active low |
| rd_data_o | output | DW | Registered read data or status word |

## Verification
The bench breaks key sequences with a wrong data byte and with an address off by one. A decoder that checked only the data, or that stayed armed after a mismatch, would program a word that must stay erased. It changes the address and data while the strobe is low, which catches a model that samples the wrong strobe edge. It programs a word twice, where a plain overwrite would show up instead of the AND. It checks that a sector erase spares the other sectors and that chip erase is refused under write protect. It sends a full program sequence during a chip erase. A model that listened while busy, or that came out of the busy phase still armed, would then leave a cleared word behind. It also checks the exact status sequence 0x0000, 0x0044, 0x0000 and confirms that the toggle continues across ignored writes.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROG,
    ST_ERA1,
    ST_ERA2,
    ST_ERA3
  } seq_st_e;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_SECT_A = 8'h30;
  localparam logic [7:0] OP_SECT_B = 8'h50;
  localparam logic [7:0] OP_ID_IN  = 8'h90;
  localparam logic [7:0] OP_ID_OUT = 8'hF0;

  localparam int TOG_HI = 6;
  localparam int TOG_LO = 2;

endpackage

// File: rtl/nor_strobe_cap.sv
module nor_strobe_cap #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cyc_v_o,
  output logic [AW-1:0] cyc_addr_o,
  output logic [DW-1:0] cyc_data_o
);

  logic          wr_q;
  logic [AW-1:0] addr_hold_q;
  logic          fall, rise;

  assign fall = wr_q & ~wr_n_i;
  assign rise = ~wr_q & wr_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q        <= 1'b1;
      addr_hold_q <= '0;
      cyc_v_o     <= 1'b0;
      cyc_addr_o  <= '0;
      cyc_data_o  <= '0;
    end else begin
      wr_q    <= wr_n_i;
      cyc_v_o <= rise;
      if (fall) addr_hold_q <= addr_i;
      if (rise) begin
        cyc_addr_o <= addr_hold_q;
        cyc_data_o <= data_i;
      end
    end
  end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter logic [AW-1:0] KEY1_ADDR = AW'(16'h5555),
  parameter logic [AW-1:0] KEY2_ADDR = AW'(16'h2AAA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_v_i,
  input  logic [AW-1:0] cyc_addr_i,
  input  logic [DW-1:0] cyc_data_i,
  input  logic          busy_i,
  input  logic          wp_ni,
  output logic          prog_go_o,
  output logic          sect_go_o,
  output logic          chip_go_o,
  output logic          id_mode_o,
  output logic          idle_o
);

  seq_st_e    st_q, st_d;
  logic       id_q, id_d;
  logic [7:0] lo;
  logic       at1, at2;

  assign lo  = cyc_data_i[7:0];
  assign at1 = (cyc_addr_i == KEY1_ADDR);
  assign at2 = (cyc_addr_i == KEY2_ADDR);

  always_comb begin
    st_d      = st_q;
    id_d      = id_q;
    prog_go_o = 1'b0;
    sect_go_o = 1'b0;
    chip_go_o = 1'b0;
    if (cyc_v_i && !busy_i) begin
      unique case (st_q)
        ST_IDLE: st_d = (at1 && lo == KEY_A) ? ST_KEY1 : ST_IDLE;
        ST_KEY1: st_d = (at2 && lo == KEY_B) ? ST_KEY2 : ST_IDLE;
        ST_KEY2: begin
          st_d = ST_IDLE;
          if (at1) begin
            if (lo == OP_PROG)   st_d = ST_PROG;
            if (lo == OP_ERASE)  st_d = ST_ERA1;
            if (lo == OP_ID_IN)  id_d = 1'b1;
            if (lo == OP_ID_OUT) id_d = 1'b0;
          end
        end
        ST_PROG: begin
          prog_go_o = 1'b1;
          st_d      = ST_IDLE;
        end
        ST_ERA1: st_d = (at1 && lo == KEY_A) ? ST_ERA2 : ST_IDLE;
        ST_ERA2: st_d = (at2 && lo == KEY_B) ? ST_ERA3 : ST_IDLE;
        ST_ERA3: begin
          st_d = ST_IDLE;
          if (at1 && lo == OP_CHIP)                    chip_go_o = wp_ni;
          else if (lo == OP_SECT_A || lo == OP_SECT_B) sect_go_o = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      id_q <= 1'b0;
    end else begin
      st_q <= st_d;
      id_q <= id_d;
    end
  end

  assign id_mode_o = id_q;
  assign idle_o    = (st_q == ST_IDLE);

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 24,
  parameter int CHIP_CYC = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_go_i,
  input  logic sect_go_i,
  input  logic chip_go_i,
  output logic busy_o
);

  localparam int MAX_PS = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C  = (MAX_PS > CHIP_CYC) ? MAX_PS : CHIP_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (chip_go_i)         cnt_q <= CW'(CHIP_CYC);
    else if (sect_go_i)         cnt_q <= CW'(SECT_CYC);
    else if (prog_go_i)         cnt_q <= CW'(PROG_CYC);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_cmd_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 16,
  parameter int          MEM_AW  = 6,
  parameter int          SECT_AW = 4,
  parameter logic [DW-1:0] MFR_ID = DW'(16'h00BF),
  parameter logic [DW-1:0] DEV_ID = DW'(16'h27C3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_go_i,
  input  logic              sect_go_i,
  input  logic              chip_go_i,
  input  logic [MEM_AW-1:0] op_addr_i,
  input  logic [DW-1:0]     op_data_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic              busy_i,
  input  logic              id_mode_i,
  output logic [DW-1:0]     rd_data_o
);

  localparam int NWORDS = 1 << MEM_AW;
  localparam int SW     = MEM_AW - SECT_AW;

  logic [NWORDS-1:0][DW-1:0] words;
  logic [SW-1:0]             op_sect;
  logic                      launch;
  logic                      tog_q;
  logic [DW-1:0]             stat_w;

  assign op_sect = op_addr_i[MEM_AW-1:SECT_AW];
  assign launch  = prog_go_i | sect_go_i | chip_go_i;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    localparam logic [MEM_AW-1:0] IDX = MEM_AW'(g);
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q <= '1;
      else if (chip_go_i || (sect_go_i && op_sect == IDX[MEM_AW-1:SECT_AW]))
        word_q <= '1;
      else if (prog_go_i && op_addr_i == IDX)
        word_q <= word_q & op_data_i;
    end
    assign words[g] = word_q;
  end

  always_comb begin
    stat_w         = '0;
    stat_w[TOG_HI] = tog_q;
    stat_w[TOG_LO] = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      tog_q     <= 1'b0;
    end else begin
      if (rd_i && busy_i) tog_q <= ~tog_q;
      else if (launch)    tog_q <= 1'b0;
      if (rd_i) begin
        if (busy_i)                                  rd_data_o <= stat_w;
        else if (id_mode_i && rd_addr_i == '0)       rd_data_o <= MFR_ID;
        else if (id_mode_i && rd_addr_i == AW'(1))   rd_data_o <= DEV_ID;
        else                                         rd_data_o <= words[rd_addr_i[MEM_AW-1:0]];
      end
    end
  end

endmodule

// File: rtl/nor_cmd_model.sv
module nor_cmd_model #(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          MEM_AW    = 6,
  parameter int          SECT_AW   = 4,
  parameter int          PROG_CYC  = 8,
  parameter int          SECT_CYC  = 24,
  parameter int          CHIP_CYC  = 48,
  parameter logic [AW-1:0] KEY1_ADDR = AW'(16'h5555),
  parameter logic [AW-1:0] KEY2_ADDR = AW'(16'h2AAA),
  parameter logic [DW-1:0] MFR_ID    = DW'(16'h00BF),
  parameter logic [DW-1:0] DEV_ID    = DW'(16'h27C3)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_n_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          wp_ni,
  output logic [DW-1:0] rd_data_o
);

  logic          cyc_v;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  logic          prog_go, sect_go, chip_go;
  logic          id_mode, seq_idle, busy;

  nor_strobe_cap #(.AW(AW), .DW(DW)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_n_i     (wr_n_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .cyc_v_o    (cyc_v),
    .cyc_addr_o (cyc_addr),
    .cyc_data_o (cyc_data)
  );

  nor_seq_fsm #(
    .AW(AW), .DW(DW), .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_v_i    (cyc_v),
    .cyc_addr_i (cyc_addr),
    .cyc_data_i (cyc_data),
    .busy_i     (busy),
    .wp_ni      (wp_ni),
    .prog_go_o  (prog_go),
    .sect_go_o  (sect_go),
    .chip_go_o  (chip_go),
    .id_mode_o  (id_mode),
    .idle_o     (seq_idle)
  );

  nor_busy_timer #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_go_i (prog_go),
    .sect_go_i (sect_go),
    .chip_go_i (chip_go),
    .busy_o    (busy)
  );

  nor_array #(
    .AW(AW), .DW(DW), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_go_i (prog_go),
    .sect_go_i (sect_go),
    .chip_go_i (chip_go),
    .op_addr_i (cyc_addr[MEM_AW-1:0]),
    .op_data_i (cyc_data),
    .rd_i      (rd_i),
    .rd_addr_i (addr_i),
    .busy_i    (busy),
    .id_mode_i (id_mode),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/nor_cmd_model_chk.sv
module nor_cmd_model_chk #(
  parameter int          AW     = 16,
  parameter int          DW     = 16,
  parameter logic [DW-1:0] MFR_ID = DW'(16'h00BF)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rd_data_o,
  input logic          busy,
  input logic          id_mode,
  input logic          seq_idle,
  input logic          prog_go,
  input logic          sect_go,
  input logic          chip_go
);

  localparam logic [DW-1:0] STAT_MASK = DW'(16'h0044);

  AST_BUSY_STATUS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && rd_i |=> (rd_data_o & ~STAT_MASK) == '0); // R6
  AST_BUSY_PAIR_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && rd_i |=> rd_data_o[6] == rd_data_o[2]); // R6
  AST_BUSY_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_i) ##1 (busy && rd_i) |=> rd_data_o != $past(rd_data_o)); // R6
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o)); // R10
  AST_IDLE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> seq_idle); // R7
  AST_NO_JOB_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(prog_go || sect_go || chip_go)); // R7
  AST_ONE_JOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_go, sect_go, chip_go})); // R3
  AST_ID_VENDOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && id_mode && rd_i && addr_i == '0 |=> rd_data_o == MFR_ID); // R8

endmodule

bind nor_cmd_model nor_cmd_model_chk #(.AW(AW), .DW(DW), .MFR_ID(MFR_ID)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .busy      (busy),
  .id_mode   (id_mode),
  .seq_idle  (seq_idle),
  .prog_go   (prog_go),
  .sect_go   (sect_go),
  .chip_go   (chip_go)
);

// File: tb/nor_cmd_model_bench.sv
`timescale 1ns/1ps
module nor_cmd_model_bench;

  localparam logic [15:0] DEV_ID = 16'h27C3;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OWT = 2'd2;
  localparam int NV = 62;

  // {op, req, addr, value}
  localparam logic [37:0] VEC [NV] = '{
    {ORD, 4'd1, 16'h0003, 16'hFFFF},            // R1
    {ORD, 4'd1, 16'h003F, 16'hFFFF},            // R1
    {OW,  4'd3, 16'h5555, 16'h00AA},
    {OW,  4'd3, 16'h2AAA, 16'h0055},
    {OW,  4'd3, 16'h5555, 16'h00A0},
    {OW,  4'd3, 16'h0003, 16'h1234},
    {ORD, 4'd6, 16'h0003, 16'h0000},            // R6 first busy read
    {ORD, 4'd6, 16'h0010, 16'h0044},            // R6
    {ORD, 4'd6, 16'h0003, 16'h0000},            // R6
    {OWT, 4'd0, 16'h0000, 16'd16},
    {ORD, 4'd3, 16'h0003, 16'h1234},            // R3
    {OW,  4'd3, 16'h5555, 16'h00AA},
    {OW,  4'd3, 16'h2AAA, 16'h0055},
    {OW,  4'd3, 16'h5555, 16'h00A0},
    {OW,  4'd3, 16'h0003, 16'h00FF},
    {OWT, 4'd0, 16'h0000, 16'd16},
    {ORD, 4'd3, 16'h0003, 16'h0034},            // R3 AND
    {OW,  4'd8, 16'h5555, 16'h00AA},
    {OW,  4'd8, 16'h2AAA, 16'h0055},
    {OW,  4'd8, 16'h5555, 16'h0090},
    {ORD, 4'd8, 16'h0000, 16'h00BF},            // R8
    {ORD, 4'd8, 16'h0001, DEV_ID},              // R8
    {ORD, 4'd8, 16'h0003, 16'h0034},            // R8
    {OW,  4'd8, 16'h5555, 16'h00AA},
    {OW,  4'd8, 16'h2AAA, 16'h0055},
    {OW,  4'd8, 16'h5555, 16'h00F0},
    {ORD, 4'd8, 16'h0000, 16'hFFFF},            // R8 exit
    {OW,  4'd3, 16'h5555, 16'h00AA},
    {OW,  4'd3, 16'h2AAA, 16'h0055},
    {OW,  4'd3, 16'h5555, 16'h00A0},
    {OW,  4'd3, 16'h0013, 16'h0F0F},
    {OWT, 4'd0, 16'h0000, 16'd16},
    {ORD, 4'd3, 16'h0013, 16'h0F0F},            // R3
    {OW,  4'd4, 16'h5555, 16'h00AA},
    {OW,  4'd4, 16'h2AAA, 16'h0055},
    {OW,  4'd4, 16'h5555, 16'h0080},
    {OW,  4'd4, 16'h5555, 16'h00AA},
    {OW,  4'd4, 16'h2AAA, 16'h0055},
    {OW,  4'd4, 16'h0011, 16'h0030},
    {ORD, 4'd6, 16'h0013, 16'h0000},            // R6
    {OWT, 4'd0, 16'h0000, 16'd40},
    {ORD, 4'd4, 16'h0013, 16'hFFFF},            // R4
    {ORD, 4'd4, 16'h0003, 16'h0034},            // R4 other sector kept
    {OW,  4'd4, 16'h5555, 16'h00AA},
    {OW,  4'd4, 16'h2AAA, 16'h0055},
    {OW,  4'd4, 16'h5555, 16'h0080},
    {OW,  4'd4, 16'h5555, 16'h00AA},
    {OW,  4'd4, 16'h2AAA, 16'h0055},
    {OW,  4'd4, 16'h0002, 16'h0050},
    {OWT, 4'd0, 16'h0000, 16'd40},
    {ORD, 4'd4, 16'h0003, 16'hFFFF},            // R4 code 0x50
    {OW,  4'd2, 16'h5555, 16'h00AA},
    {OW,  4'd2, 16'h2AAA, 16'h0056},
    {OW,  4'd2, 16'h5555, 16'h00A0},
    {OW,  4'd2, 16'h0005, 16'h0000},
    {ORD, 4'd2, 16'h0005, 16'hFFFF},            // R2 bad data
    {ORD, 4'd2, 16'h0005, 16'hFFFF},            // R2 no busy
    {OW,  4'd2, 16'h5555, 16'h00AA},
    {OW,  4'd2, 16'h2AAB, 16'h0055},
    {OW,  4'd2, 16'h5555, 16'h00A0},
    {OW,  4'd2, 16'h0006, 16'h0000},
    {ORD, 4'd2, 16'h0006, 16'hFFFF}             // R2 bad address
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic        rd = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        wp_n = 1'b1;
  logic [15:0] rd_data;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  nor_cmd_model u_nor_cmd_model (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_n_i    (wr_n),
    .rd_i      (rd),
    .addr_i    (addr),
    .data_i    (data),
    .wp_ni     (wp_n),
    .rd_data_o (rd_data)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; data = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic seq_prog(input logic [15:0] a, input logic [15:0] d);
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
    bus_wr(16'h5555, 16'h00A0);
    bus_wr(a, d);
  endtask

  task automatic seq_chip();
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
    bus_wr(16'h5555, 16'h0080);
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
    bus_wr(16'h5555, 16'h0010);
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [15:0] a, v;
      {op, rq, a, v} = VEC[i];
      if (op == OW) bus_wr(a, v);
      else if (op == OWT) repeat (int'(v)) @(negedge clk);
      else rd_chk($sformatf("R%0d", rq), a, v);
    end

    // R5: chip erase refused under write protect
    seq_prog(16'h0008, 16'h0000);
    repeat (16) @(negedge clk);
    wp_n = 1'b0;
    seq_chip();
    rd_chk("R5", 16'h0008, 16'h0000);
    rd_chk("R5", 16'h0008, 16'h0000);
    wp_n = 1'b1;

    // R5/R6/R7: chip erase, program attempt while busy
    seq_chip();
    rd_chk("R6", 16'h0008, 16'h0000);
    rd_chk("R6", 16'h0008, 16'h0044);
    seq_prog(16'h0030, 16'h0000);
    rd_chk("R7", 16'h0008, 16'h0000);
    repeat (60) @(negedge clk);
    rd_chk("R5", 16'h0008, 16'hFFFF);
    rd_chk("R7", 16'h0030, 16'hFFFF);
    bus_wr(16'h0030, 16'h0000);
    rd_chk("R7", 16'h0030, 16'hFFFF);

    // R9: address at strobe fall, data at strobe rise
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
    bus_wr(16'h5555, 16'h00A0);
    @(negedge clk); addr = 16'h0007; data = 16'h0000; wr_n = 1'b0;
    @(negedge clk); addr = 16'h0009; data = 16'h5A5A;
    @(negedge clk); wr_n = 1'b1;
    repeat (20) @(negedge clk);
    rd_chk("R9", 16'h0007, 16'h5A5A);
    rd_chk("R9", 16'h0009, 16'hFFFF);

    // R10: output holds without a read
    held = rd_data;
    @(negedge clk); addr = 16'h0007;
    repeat (4) @(negedge clk);
    check("R10", rd_data, held);

    // R1: reset mid-sequence restores erased array
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", rd_data, 16'h0000);
    rst_n = 1'b1;
    rd_chk("R1", 16'h0007, 16'hFFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule